// File: doc/BRIEF.md
# Sector Error Bit Correction Engine

This block repairs a page after the decoder has found where its errors are. It takes a status word with one bit per sector and looks at the sectors in order, starting with bit 0. For each sector whose bit is set, it asks the upstream error store for three things: the degree of that sector's locator polynomial, the number of roots found, and the list of error positions. A position names one bit of the sector's codeword, which is the data bytes followed by the sector's check bytes. Each position becomes a single-bit flip, applied with a read-modify-write on either the data buffer or the check-byte buffer.

A run starts with a scan of every stored check byte. If all of them hold 0xFF, the page has never been programmed. The engine then reports it as erased and changes nothing. A sector whose root count differs from its locator degree cannot be repaired, so the engine stops there and reports a failure. A position that points past the end of the sector's codeword means the error list is corrupt. The engine stops on it and raises a fault flag. The engine also counts how many bits it corrected across the whole page.

The upstream error store and both buffers answer in the same cycle: the engine presents a sector index or an address, and the data it needs is read back in that cycle.

Top module: `sector_bitfix`

## Requirements
- R1: Before any correction, the engine reads check bytes 0 to NUM_SECTORS*EBPS-1 in order. If every one of them is 0xFF, it finishes with `erased` set, `corr_count` at 0 and no write to either buffer. The first byte that is not 0xFF ends the scan.
- R2: Sectors are handled in ascending order, starting from bit 0 of `sec_status`. A sector whose bit is clear is skipped, and no entry of its error list is applied.
- R3: A position p is 1-based. With k = p-1, the byte index is k/8 and the bit index is k%8. Each position toggles exactly that bit with one write. One position is handled per cycle, in list order, from index 0 to `root_count`-1.
- R4: If the byte index is below SECTOR_BYTES, the flip goes to data address sector*SECTOR_BYTES + byte.
- R5: Otherwise the flip goes to check-byte address sector*EBPS + (byte - SECTOR_BYTES).
- R6: A byte index at or above SECTOR_BYTES+EBPS sets `fault` and ends the run with no write for that position. Flips that were already made stay in place.
- R7: If a selected sector's `root_count` differs from its `loc_degree`, the engine sets `failed` and ends the run. That sector and every later sector are left untouched, and earlier corrections stay in place.
- R8: EBPS = ceil((12 + SECTOR_BYTES/512) * T_CAP / 8). The defaults (512-byte sectors, T_CAP = 8) give 13.
- R9: `corr_count` is the total number of bits flipped in the run. `done` is set when the run ends and, like `corr_count`, holds until the next `start`. `busy` is high only while a run is in progress.
- R10: After reset the engine is idle: `busy`, `done`, `erased`, `failed`, `fault` and both write enables are low, and `corr_count` is 0.
- R11: A selected sector with zero roots and degree zero causes no write, and processing continues with the next sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run and latches `sec_status` |
| sec_status | input | NUM_SECTORS | One bit per sector that needs correction |
| err_sel | output | SECT_W | Sector whose error information is requested |
| loc_degree | input | CNT_W | Locator degree of the selected sector |
| root_count | input | CNT_W | Number of roots found for the selected sector |
| pos_idx | output | CNT_W | Index into the selected sector's position list |
| err_pos | input | POS_W | 1-based bit position at `pos_idx` |
| dat_addr | output | DADDR_W | Data buffer byte address |
| dat_rd_data | input | 8 | Data byte at `dat_addr` |
| dat_wr_en | output | 1 | Data buffer write strobe |
| dat_wr_data | output | 8 | Corrected data byte |
| ecc_addr | output | EADDR_W | Check-byte buffer address |
| ecc_rd_data | input | 8 | Check byte at `ecc_addr` |
| ecc_wr_en | output | 1 | Check-byte write strobe |
| ecc_wr_data | output | 8 | Corrected check byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next start |
| erased | output | 1 | Page was detected as erased |
| failed | output | 1 | A sector could not be corrected |
| fault | output | 1 | An error position was out of range |
| corr_count | output | CORR_W | Bits corrected in the run |

## Verification
The assertions assume that `start` is pulsed only while the engine is idle or done. They also assume that the buffers and the error store answer in the same cycle with values that stay stable while the engine holds an address. A flip is checked by comparing the write data against the read data, so the assertions depend on that same-cycle read. The bench keeps to these assumptions: it models the buffers and the error tables as combinational lookups, loads them only while the engine is idle, and pulses `start` for one cycle after each run has been checked.

// File: rtl/sector_bitfix_pkg.sv
package sector_bitfix_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_SCAN,
        ST_FLIP,
        ST_DONE
    } fix_state_e;

    // Check bytes per sector: field width times capability, rounded up to bytes.
    function automatic int ecc_bytes_per_sector(input int sector_bytes, input int t_cap);
        int m;
        m = 12 + sector_bytes / 512;
        return (m * t_cap + 7) / 8;
    endfunction

endpackage

// File: rtl/bitfix_pos_map.sv
module bitfix_pos_map #(
    parameter int SECTOR_BYTES = 512,
    parameter int EBPS         = 13,
    parameter int POS_W        = 13,
    parameter int SECT_W       = 2,
    parameter int DADDR_W      = 11,
    parameter int EADDR_W      = 6
) (
    input  logic [POS_W-1:0]   pos,
    input  logic [SECT_W-1:0]  sector,
    output logic               in_data,
    output logic               out_of_range,
    output logic [2:0]         bit_idx,
    output logic [DADDR_W-1:0] dat_addr,
    output logic [EADDR_W-1:0] ecc_addr
);
    localparam int BYTE_W = POS_W - 3;

    logic [POS_W-1:0]  zero_based;
    logic [BYTE_W-1:0] byte_idx;
    logic [BYTE_W-1:0] ecc_off;

    always_comb begin
        zero_based   = pos - POS_W'(1);
        byte_idx     = zero_based[POS_W-1:3];
        bit_idx      = zero_based[2:0];
        in_data      = byte_idx < BYTE_W'(SECTOR_BYTES);
        out_of_range = byte_idx >= BYTE_W'(SECTOR_BYTES + EBPS);
        ecc_off      = byte_idx - BYTE_W'(SECTOR_BYTES);
        dat_addr     = DADDR_W'(sector) * DADDR_W'(SECTOR_BYTES) + DADDR_W'(byte_idx);
        ecc_addr     = EADDR_W'(sector) * EADDR_W'(EBPS) + EADDR_W'(ecc_off);
    end

endmodule

// File: rtl/bitfix_rmw.sv
module bitfix_rmw (
    input  logic       act,
    input  logic       in_data,
    input  logic [2:0] bit_idx,
    input  logic [7:0] dat_rd,
    input  logic [7:0] ecc_rd,
    output logic       dat_we,
    output logic       ecc_we,
    output logic [7:0] dat_wd,
    output logic [7:0] ecc_wd
);
    logic [7:0] mask;

    always_comb begin
        mask   = 8'b1 << bit_idx;
        dat_we = act & in_data;
        ecc_we = act & ~in_data;
        dat_wd = dat_rd ^ mask;
        ecc_wd = ecc_rd ^ mask;
    end

endmodule

// File: rtl/sector_bitfix.sv
module sector_bitfix
    import sector_bitfix_pkg::*;
#(
    parameter int NUM_SECTORS  = 4,
    parameter int SECTOR_BYTES = 512,
    parameter int T_CAP        = 8,
    localparam int EBPS      = ecc_bytes_per_sector(SECTOR_BYTES, T_CAP),
    localparam int ECC_TOTAL = NUM_SECTORS * EBPS,
    localparam int SECT_W    = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
    localparam int DADDR_W   = $clog2(NUM_SECTORS * SECTOR_BYTES),
    localparam int EADDR_W   = (ECC_TOTAL > 1) ? $clog2(ECC_TOTAL) : 1,
    localparam int CNT_W     = $clog2(T_CAP + 1),
    localparam int POS_W     = $clog2((SECTOR_BYTES + EBPS) * 8 + 1),
    localparam int CORR_W    = $clog2(NUM_SECTORS * T_CAP + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_SECTORS-1:0] sec_status,
    output logic [SECT_W-1:0]      err_sel,
    input  logic [CNT_W-1:0]       loc_degree,
    input  logic [CNT_W-1:0]       root_count,
    output logic [CNT_W-1:0]       pos_idx,
    input  logic [POS_W-1:0]       err_pos,
    output logic [DADDR_W-1:0]     dat_addr,
    input  logic [7:0]             dat_rd_data,
    output logic                   dat_wr_en,
    output logic [7:0]             dat_wr_data,
    output logic [EADDR_W-1:0]     ecc_addr,
    input  logic [7:0]             ecc_rd_data,
    output logic                   ecc_wr_en,
    output logic [7:0]             ecc_wr_data,
    output logic                   busy,
    output logic                   done,
    output logic                   erased,
    output logic                   failed,
    output logic                   fault,
    output logic [CORR_W-1:0]      corr_count
);

    typedef struct packed {
        fix_state_e             state;
        logic [NUM_SECTORS-1:0] pend;
        logic [SECT_W-1:0]      sec;
        logic [CNT_W-1:0]       pidx;
        logic [EADDR_W-1:0]     eaddr;
        logic [CORR_W-1:0]      corr;
        logic                   erased;
        logic                   failed;
        logic                   fault;
    } fix_regs_t;

    fix_regs_t r_q, r_d;

    logic               map_in_data;
    logic               map_oor;
    logic [2:0]         map_bit;
    logic [DADDR_W-1:0] map_dat_addr;
    logic [EADDR_W-1:0] map_ecc_addr;
    logic               flip_act;
    logic               step_next;

    bitfix_pos_map #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .EBPS        (EBPS),
        .POS_W       (POS_W),
        .SECT_W      (SECT_W),
        .DADDR_W     (DADDR_W),
        .EADDR_W     (EADDR_W)
    ) u_map (
        .pos         (err_pos),
        .sector      (r_q.sec),
        .in_data     (map_in_data),
        .out_of_range(map_oor),
        .bit_idx     (map_bit),
        .dat_addr    (map_dat_addr),
        .ecc_addr    (map_ecc_addr)
    );

    bitfix_rmw u_rmw (
        .act    (flip_act),
        .in_data(map_in_data),
        .bit_idx(map_bit),
        .dat_rd (dat_rd_data),
        .ecc_rd (ecc_rd_data),
        .dat_we (dat_wr_en),
        .ecc_we (ecc_wr_en),
        .dat_wd (dat_wr_data),
        .ecc_wd (ecc_wr_data)
    );

    always_comb begin
        r_d       = r_q;
        flip_act  = 1'b0;
        step_next = 1'b0;
        case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.state  = ST_ERASE;
                    r_d.pend   = sec_status;
                    r_d.sec    = '0;
                    r_d.pidx   = '0;
                    r_d.eaddr  = '0;
                    r_d.corr   = '0;
                    r_d.erased = 1'b0;
                    r_d.failed = 1'b0;
                    r_d.fault  = 1'b0;
                end
            end
            ST_ERASE: begin
                if (ecc_rd_data != 8'hFF) begin
                    r_d.state = ST_SCAN;
                end else if (r_q.eaddr == EADDR_W'(ECC_TOTAL - 1)) begin
                    r_d.state  = ST_DONE;
                    r_d.erased = 1'b1;
                end else begin
                    r_d.eaddr = r_q.eaddr + EADDR_W'(1);
                end
            end
            ST_SCAN: begin
                if (!r_q.pend[0]) begin
                    step_next = 1'b1;
                end else if (root_count != loc_degree) begin
                    r_d.failed = 1'b1;
                    r_d.state  = ST_DONE;
                end else if (root_count == '0) begin
                    step_next = 1'b1;
                end else begin
                    r_d.pidx  = '0;
                    r_d.state = ST_FLIP;
                end
            end
            ST_FLIP: begin
                if (map_oor) begin
                    r_d.fault = 1'b1;
                    r_d.state = ST_DONE;
                end else begin
                    flip_act = 1'b1;
                    r_d.corr = r_q.corr + CORR_W'(1);
                    if (r_q.pidx == root_count - CNT_W'(1)) begin
                        step_next = 1'b1;
                    end else begin
                        r_d.pidx = r_q.pidx + CNT_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (step_next) begin
            if (r_q.sec == SECT_W'(NUM_SECTORS - 1)) begin
                r_d.state = ST_DONE;
            end else begin
                r_d.sec   = r_q.sec + SECT_W'(1);
                r_d.pend  = r_q.pend >> 1;
                r_d.state = ST_SCAN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign err_sel    = r_q.sec;
    assign pos_idx    = r_q.pidx;
    assign dat_addr   = map_dat_addr;
    assign ecc_addr   = (r_q.state == ST_ERASE) ? r_q.eaddr : map_ecc_addr;
    assign busy       = (r_q.state == ST_ERASE) || (r_q.state == ST_SCAN) || (r_q.state == ST_FLIP);
    assign done       = (r_q.state == ST_DONE);
    assign erased     = r_q.erased;
    assign failed     = r_q.failed;
    assign fault      = r_q.fault;
    assign corr_count = r_q.corr;

endmodule

// File: rtl/sector_bitfix_chk.sv
module sector_bitfix_chk #(
    parameter int CORR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              erased,
    input logic              failed,
    input logic              fault,
    input logic              dat_wr_en,
    input logic              ecc_wr_en,
    input logic [7:0]        dat_rd_data,
    input logic [7:0]        dat_wr_data,
    input logic [7:0]        ecc_rd_data,
    input logic [7:0]        ecc_wr_data,
    input logic [CORR_W-1:0] corr_count
);

    AST_ERASED_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        erased |-> (corr_count == '0)) else $error("erased with corrections"); // R1

    AST_DAT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr_en |-> ($countones(dat_wr_data ^ dat_rd_data) == 1)) else $error("data flip not single bit"); // R3

    AST_ECC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_wr_en |-> ($countones(ecc_wr_data ^ ecc_rd_data) == 1)) else $error("ecc flip not single bit"); // R5

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dat_wr_en, ecc_wr_en})) else $error("both buffers written"); // R4

    AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !dat_wr_en && !ecc_wr_en)) else $error("fault without done"); // R6

    AST_FAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> (done && !dat_wr_en && !ecc_wr_en)) else $error("failed without done"); // R7

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_en || ecc_wr_en) |-> busy) else $error("write while not busy"); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(corr_count))) else $error("done not held"); // R9

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)) else $error("busy and done together"); // R9

endmodule

bind sector_bitfix sector_bitfix_chk #(.CORR_W(CORR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .erased     (erased),
    .failed     (failed),
    .fault      (fault),
    .dat_wr_en  (dat_wr_en),
    .ecc_wr_en  (ecc_wr_en),
    .dat_rd_data(dat_rd_data),
    .dat_wr_data(dat_wr_data),
    .ecc_rd_data(ecc_rd_data),
    .ecc_wr_data(ecc_wr_data),
    .corr_count (corr_count)
);

// File: tb/sector_bitfix_test.sv
module sector_bitfix_test;

    localparam int NS = 4;
    localparam int SB = 512;
    localparam int TC = 8;
    localparam int EB = 13;
    localparam int ET = NS * EB;
    localparam int DT = NS * SB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  sec_status = '0;
    logic [1:0]  err_sel;
    logic [3:0]  loc_degree, root_count, pos_idx;
    logic [12:0] err_pos;
    logic [10:0] dat_addr;
    logic [7:0]  dat_rd_data, dat_wr_data, ecc_rd_data, ecc_wr_data;
    logic [5:0]  ecc_addr;
    logic        dat_wr_en, ecc_wr_en, busy, done, erased, failed, fault;
    logic [5:0]  corr_count;

    always #2.5 clk = ~clk;

    // Buffers and error tables
    logic [7:0]  dat_mem [DT];
    logic [7:0]  ecc_mem [ET];
    logic [7:0]  stg_dat [DT];
    logic [7:0]  stg_ecc [ET];
    logic [7:0]  exp_dat [DT];
    logic [7:0]  exp_ecc [ET];
    logic [12:0] pos_tab [NS][TC];
    logic [3:0]  deg_tab [NS];
    logic [3:0]  cnt_tab [NS];
    logic        load_req = 1'b0;

    assign dat_rd_data = dat_mem[dat_addr];
    assign ecc_rd_data = (int'(ecc_addr) < ET) ? ecc_mem[ecc_addr] : 8'h00;
    assign loc_degree  = deg_tab[err_sel];
    assign root_count  = cnt_tab[err_sel];
    assign err_pos     = (pos_idx < 4'(TC)) ? pos_tab[err_sel][pos_idx[2:0]] : '0;

    sector_bitfix uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sec_status(sec_status),
        .err_sel(err_sel), .loc_degree(loc_degree), .root_count(root_count),
        .pos_idx(pos_idx), .err_pos(err_pos),
        .dat_addr(dat_addr), .dat_rd_data(dat_rd_data), .dat_wr_en(dat_wr_en),
        .dat_wr_data(dat_wr_data),
        .ecc_addr(ecc_addr), .ecc_rd_data(ecc_rd_data), .ecc_wr_en(ecc_wr_en),
        .ecc_wr_data(ecc_wr_data),
        .busy(busy), .done(done), .erased(erased), .failed(failed),
        .fault(fault), .corr_count(corr_count)
    );

    initial begin
        forever begin
            @(posedge clk);
            if (load_req) begin
                for (int i = 0; i < DT; i++) dat_mem[i] <= stg_dat[i];
                for (int i = 0; i < ET; i++) ecc_mem[i] <= stg_ecc[i];
            end else begin
                if (dat_wr_en) dat_mem[dat_addr] <= dat_wr_data;
                if (ecc_wr_en && int'(ecc_addr) < ET) ecc_mem[ecc_addr] <= ecc_wr_data;
            end
        end
    end

    typedef struct {
        bit         is_ecc;
        int         addr;
        logic [7:0] data;
    } wr_t;

    typedef struct {
        string name;
        int    corr;
        bit    erased;
        bit    failed;
        bit    fault;
    } res_t;

    wr_t  wq[$];
    res_t rq[$];
    int   checks = 0;
    int   errors = 0;
    int   seen   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Scenario construction
    task automatic clear_scn(input bit ecc_erased);
        for (int i = 0; i < DT; i++) begin
            stg_dat[i] = 8'(i * 7 + 3);
            exp_dat[i] = stg_dat[i];
        end
        for (int i = 0; i < ET; i++) begin
            stg_ecc[i] = ecc_erased ? 8'hFF : 8'(i);
            exp_ecc[i] = stg_ecc[i];
        end
        for (int s = 0; s < NS; s++) begin
            deg_tab[s] = '0;
            cnt_tab[s] = '0;
            for (int k = 0; k < TC; k++) pos_tab[s][k] = '0;
        end
    endtask

    task automatic add_pos(input int s, input int p);
        pos_tab[s][cnt_tab[s][2:0]] = 13'(p);
        cnt_tab[s] = cnt_tab[s] + 4'd1;
        deg_tab[s] = cnt_tab[s];
    endtask

    // Expected flip from the position rules of R3, R4 and R5
    task automatic add_flip(input int s, input int p);
        int k, byt, bt, a;
        wr_t w;
        k   = p - 1;
        byt = k / 8;
        bt  = k % 8;
        if (byt < SB) begin
            a = s * SB + byt;
            exp_dat[a] = exp_dat[a] ^ (8'h01 << bt);
            w = '{is_ecc: 1'b0, addr: a, data: exp_dat[a]};
        end else begin
            a = s * EB + byt - SB;
            exp_ecc[a] = exp_ecc[a] ^ (8'h01 << bt);
            w = '{is_ecc: 1'b1, addr: a, data: exp_ecc[a]};
        end
        wq.push_back(w);
        add_pos(s, p);
    endtask

    task automatic run_scn(input string name, input logic [3:0] status, input int corr,
                           input bit er, input bit fl, input bit ft);
        int target;
        res_t r;
        r = '{name: name, corr: corr, erased: er, failed: fl, fault: ft};
        rq.push_back(r);
        target = seen + 1;
        @(negedge clk);
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        sec_status = status;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (seen == target);
    endtask

    // Monitor: compares writes as they occur and results when done rises
    initial begin
        bit last_done;
        last_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (dat_wr_en || ecc_wr_en)) begin
                if (wq.size() == 0) begin
                    check(1'b0, "R3", "unexpected write", int'(dat_addr), -1);
                end else begin
                    wr_t w;
                    w = wq.pop_front();
                    check(w.is_ecc == ecc_wr_en, "R3/R4", "write target", int'(ecc_wr_en), int'(w.is_ecc));
                    if (!w.is_ecc) begin
                        check(int'(dat_addr) == w.addr, "R4", "data address", int'(dat_addr), w.addr);
                        check(dat_wr_data == w.data, "R3", "data byte", int'(dat_wr_data), int'(w.data));
                    end else begin
                        check(int'(ecc_addr) == w.addr, "R5", "check-byte address", int'(ecc_addr), w.addr);
                        check(ecc_wr_data == w.data, "R3", "check byte", int'(ecc_wr_data), int'(w.data));
                    end
                end
            end
            if (rst_n && done && !last_done) begin
                res_t r;
                int bad;
                r = rq.pop_front();
                $display("scenario %s finished", r.name);
                check(int'(corr_count) == r.corr, "R9", "corr_count", int'(corr_count), r.corr);
                check(erased == r.erased, "R1", "erased", int'(erased), int'(r.erased));
                check(failed == r.failed, "R7", "failed", int'(failed), int'(r.failed));
                check(fault == r.fault, "R6", "fault", int'(fault), int'(r.fault));
                check(!busy, "R9", "busy at done", int'(busy), 0);
                check(wq.size() == 0, "R3", "missing writes", wq.size(), 0);
                wq.delete();
                bad = 0;
                for (int i = 0; i < DT; i++) if (dat_mem[i] !== exp_dat[i]) bad++;
                check(bad == 0, "R2", "data image mismatches", bad, 0);
                bad = 0;
                for (int i = 0; i < ET; i++) if (ecc_mem[i] !== exp_ecc[i]) bad++;
                check(bad == 0, "R2", "check image mismatches", bad, 0);
                seen++;
            end
            last_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_scn(1'b0);
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy && !done, "R10", "busy/done after reset", int'({busy, done}), 0);
        check(!erased && !failed && !fault, "R10", "flags after reset", int'({erased, failed, fault}), 0);
        check(corr_count == '0 && !dat_wr_en && !ecc_wr_en, "R10", "count/writes after reset",
              int'(corr_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 fully erased page: errors listed but nothing applied
        clear_scn(1'b1);
        add_pos(0, 5);
        add_pos(2, 4100);
        run_scn("erased", 4'b1111, 0, 1'b1, 1'b0, 1'b0);

        // R2 R4 R5 R8 mixed flips; sector 1 listed but not selected
        clear_scn(1'b0);
        add_flip(0, 1);
        add_flip(0, 8);
        add_flip(0, 4096);
        add_pos(1, 20);
        add_flip(2, 4097);
        add_flip(2, 4200);
        run_scn("mixed", 4'b0101, 5, 1'b0, 1'b0, 1'b0);

        // R1 only the last check byte differs from 0xFF: not erased
        clear_scn(1'b1);
        stg_ecc[ET-1] = 8'h00;
        exp_ecc[ET-1] = 8'h00;
        add_flip(3, 100);
        add_flip(3, 4104);
        run_scn("last_byte", 4'b1000, 2, 1'b0, 1'b0, 1'b0);

        // R7 degree mismatch aborts; later sector untouched
        clear_scn(1'b0);
        add_flip(0, 33);
        add_pos(1, 50);
        add_pos(1, 60);
        deg_tab[1] = 4'd3;
        add_pos(2, 70);
        run_scn("mismatch", 4'b0111, 1, 1'b0, 1'b1, 1'b0);

        // R6 R11 empty selected sector, then out-of-range position
        clear_scn(1'b0);
        add_flip(1, 9);
        add_pos(1, SB * 8 + EB * 8 + 1);
        run_scn("fault", 4'b0011, 1, 1'b0, 1'b0, 1'b1);

        // R4 boundary addresses in the last sector
        clear_scn(1'b0);
        add_flip(3, 16);
        add_flip(3, 4096);
        run_scn("edges", 4'b1000, 2, 1'b0, 1'b0, 1'b0);

        // R11 no sector selected
        clear_scn(1'b0);
        add_pos(0, 40);
        run_scn("none", 4'b0000, 0, 1'b0, 1'b0, 1'b0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule